// File: doc/BRIEF.md
# Packed 16-bit Lane Arithmetic Unit

This unit treats each 64-bit operand as four independent 16-bit lanes and applies one arithmetic or shift operation to all lanes at once. The operations are add, subtract, unsigned average, shift-left-then-add, shift-right-then-add and three plain shifts. The lanes are fully isolated, so no carry, borrow or shifted-out bit from one lane reaches its neighbour.

Add and subtract each take an overflow policy on every request. The three policies are plain modular wrap, clamping to the signed 16-bit range and clamping to the unsigned 16-bit range. Both shift-and-add forms always clamp to the signed range. A request is presented with a one-cycle strobe. The result appears in an output register one clock later with a valid flag, and the register holds its value until the next request.

Top module: `lane_simd_alu`

## Requirements
- R1: No carry or borrow crosses a 16-bit lane boundary. Add (opSel=0) and subtract (opSel=1) wrap modulo 2^16 per lane when satMode is 0 or 3.
- R2: With satMode=1, add and subtract clamp each lane to the signed range: 0x7FFF on positive overflow and 0x8000 on negative overflow.
- R3: With satMode=2, add and subtract read both lanes as unsigned. Add clamps to 0xFFFF on carry out, and subtract clamps to 0x0000 on borrow.
- R4: Average (opSel=2) forms the 17-bit unsigned sum of each lane pair and shifts it right by one. The discarded bit is ORed into the result LSB.
- R5: Shift-left-then-add (opSel=3) shifts the signed lane of opA left by shiftAmt[1:0], adds the signed lane of opB and clamps the sum to the signed range.
- R6: Shift-right-then-add (opSel=4) shifts the lane of opA right arithmetically by shiftAmt[1:0], adds the signed lane of opB and clamps the sum to the signed range.
- R7: Plain shifts apply shiftAmt (0 to 15) to every lane. opSel=5 is an arithmetic right shift, opSel=6 is a logical right shift and opSel=7 is a left shift that fills with zeros.
- R8: When inValid is high at a clock edge, resOut carries that request's result after the edge and resValid is high for exactly that cycle. When inValid is low, resOut holds its value and resValid is low.
- R9: A synchronous active-high rst clears resOut to zero and resValid to zero.
- R10: opSel values 8 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| opSel | input | 4 | Operation select |
| satMode | input | 2 | Overflow policy for add and subtract |
| shiftAmt | input | 4 | Shift amount |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| resOut | output | 64 | Registered packed result |
| resValid | output | 1 | Result valid, one cycle after request |

## Verification
Each lane of every result is compared against a lane-by-lane integer model.

Some lane patterns are all-ones plus one, chosen so that a leaked carry would corrupt the next lane and expose any missing lane cut. Other patterns put operands at the signed and unsigned extremes, which separates the three overflow policies: the same operands give three different answers. Average cases use odd sums to expose the rounding rule. Shift cases use amounts 0, 1, 3 and 15 on negative lanes to separate arithmetic from logical shifting. A batch of random operands and a hold-and-reset sequence cover the general case and the register timing.

// File: rtl/lane_simd_pkg.sv
package lane_simd_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_AVG    = 4'd2,
    OP_SHLADD = 4'd3,
    OP_SHRADD = 4'd4,
    OP_SHRS   = 4'd5,
    OP_SHRU   = 4'd6,
    OP_SHL    = 4'd7
  } opCode_e;

  typedef enum logic [1:0] {
    SAT_WRAP   = 2'd0,
    SAT_SIGNED = 2'd1,
    SAT_UNSIGN = 2'd2,
    SAT_WRAP2  = 2'd3
  } satMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doAvg;
    logic doShlAdd;
    logic doShrAdd;
    logic doShrS;
    logic doShrU;
    logic doShl;
    logic satSigned;
    logic satUnsigned;
    logic load;
  } ctrlStrobe_t;

endpackage

// File: rtl/lane_simd_ctrl.sv
module lane_simd_ctrl
  import lane_simd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [3:0]  opSel,
  input  logic [1:0]  satMode,
  output ctrlStrobe_t strobes
);

  always_comb begin
    strobes = '0;
    strobes.load = inValid;
    unique case (opSel)
      OP_ADD:    strobes.doAdd    = 1'b1;
      OP_SUB:    strobes.doSub    = 1'b1;
      OP_AVG:    strobes.doAvg    = 1'b1;
      OP_SHLADD: strobes.doShlAdd = 1'b1;
      OP_SHRADD: strobes.doShrAdd = 1'b1;
      OP_SHRS:   strobes.doShrS   = 1'b1;
      OP_SHRU:   strobes.doShrU   = 1'b1;
      OP_SHL:    strobes.doShl    = 1'b1;
      default:   ;
    endcase
    if (opSel == OP_ADD || opSel == OP_SUB) begin
      strobes.satSigned   = (satMode == SAT_SIGNED);
      strobes.satUnsigned = (satMode == SAT_UNSIGN);
    end
  end

  // R10
  op_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.doAdd, strobes.doSub, strobes.doAvg, strobes.doShlAdd,
              strobes.doShrAdd, strobes.doShrS, strobes.doShrU, strobes.doShl}));

  // R3
  sat_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.satSigned || strobes.satUnsigned) |-> (strobes.doAdd || strobes.doSub));

endmodule

// File: rtl/lane_simd_datapath.sv
module lane_simd_datapath
  import lane_simd_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int SH_W   = $clog2(LANE_W)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrlStrobe_t               strobes,
  input  logic [LANES*LANE_W-1:0]   opA,
  input  logic [LANES*LANE_W-1:0]   opB,
  input  logic [SH_W-1:0]           shiftAmt,
  output logic [LANES*LANE_W-1:0]   resOut,
  output logic                      resValid
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int XW     = LANE_W + 4;
  localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] UMAX = {LANE_W{1'b1}};

  logic [DATA_W-1:0] laneRes;
  logic [1:0]        shAdd;

  assign shAdd = shiftAmt[1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0]        a, b, res;
    logic [LANE_W:0]          sumU, difU;
    logic [LANE_W:0]          sumS, difS;
    logic [XW-1:0]            shlA, shlSum;
    logic [LANE_W-1:0]        shrA;
    logic [LANE_W:0]          shrSum;
    logic [LANE_W-1:0]        addOut, subOut, avgOut, shlAddOut, shrAddOut;
    logic                     shlOvf;

    assign a = opA[i*LANE_W +: LANE_W];
    assign b = opB[i*LANE_W +: LANE_W];

    assign sumU = {1'b0, a} + {1'b0, b};
    assign difU = {1'b0, a} - {1'b0, b};
    assign sumS = {a[LANE_W-1], a} + {b[LANE_W-1], b};
    assign difS = {a[LANE_W-1], a} - {b[LANE_W-1], b};

    assign shlA   = {{4{a[LANE_W-1]}}, a} << shAdd;
    assign shlSum = shlA + {{4{b[LANE_W-1]}}, b};
    assign shlOvf = !((&shlSum[XW-1:LANE_W-1]) || !(|shlSum[XW-1:LANE_W-1]));

    assign shrA   = $signed(a) >>> shAdd;
    assign shrSum = {shrA[LANE_W-1], shrA} + {b[LANE_W-1], b};

    always_comb begin
      if (strobes.satSigned && (sumS[LANE_W] != sumS[LANE_W-1]))
        addOut = sumS[LANE_W] ? SMIN : SMAX;
      else if (strobes.satUnsigned && sumU[LANE_W])
        addOut = UMAX;
      else
        addOut = sumU[LANE_W-1:0];
    end

    always_comb begin
      if (strobes.satSigned && (difS[LANE_W] != difS[LANE_W-1]))
        subOut = difS[LANE_W] ? SMIN : SMAX;
      else if (strobes.satUnsigned && difU[LANE_W])
        subOut = '0;
      else
        subOut = difU[LANE_W-1:0];
    end

    assign avgOut = sumU[LANE_W:1] | {{(LANE_W-1){1'b0}}, sumU[0]};

    assign shlAddOut = shlOvf ? (shlSum[XW-1] ? SMIN : SMAX) : shlSum[LANE_W-1:0];
    assign shrAddOut = (shrSum[LANE_W] != shrSum[LANE_W-1]) ?
                       (shrSum[LANE_W] ? SMIN : SMAX) : shrSum[LANE_W-1:0];

    always_comb begin
      res = '0;
      if (strobes.doAdd)         res = addOut;
      else if (strobes.doSub)    res = subOut;
      else if (strobes.doAvg)    res = avgOut;
      else if (strobes.doShlAdd) res = shlAddOut;
      else if (strobes.doShrAdd) res = shrAddOut;
      else if (strobes.doShrS)   res = $signed(a) >>> shiftAmt;
      else if (strobes.doShrU)   res = a >> shiftAmt;
      else if (strobes.doShl)    res = a << shiftAmt;
    end

    assign laneRes[i*LANE_W +: LANE_W] = res;

    // R2
    ssat_sign_chk: assert property (@(posedge clk) disable iff (rst)
      (strobes.doAdd && strobes.satSigned && (a[LANE_W-1] == b[LANE_W-1]))
        |-> (res[LANE_W-1] == a[LANE_W-1]));

    // R3
    usat_add_chk: assert property (@(posedge clk) disable iff (rst)
      (strobes.doAdd && strobes.satUnsigned) |-> (res >= a && res >= b));

    // R3
    usat_sub_chk: assert property (@(posedge clk) disable iff (rst)
      (strobes.doSub && strobes.satUnsigned) |-> (res <= a));

    // R4
    avg_range_chk: assert property (@(posedge clk) disable iff (rst)
      strobes.doAvg |-> ((res >= a || res >= b) && (res <= a || res <= b)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resOut   <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= strobes.load;
      if (strobes.load) resOut <= laneRes;
    end
  end

endmodule

// File: rtl/lane_simd_alu.sv
module lane_simd_alu
  import lane_simd_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int SH_W   = $clog2(LANE_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [3:0]              opSel,
  input  logic [1:0]              satMode,
  input  logic [SH_W-1:0]         shiftAmt,
  input  logic [LANES*LANE_W-1:0] opA,
  input  logic [LANES*LANE_W-1:0] opB,
  output logic [LANES*LANE_W-1:0] resOut,
  output logic                    resValid
);

  ctrlStrobe_t strobes;

  lane_simd_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .opSel   (opSel),
    .satMode (satMode),
    .strobes (strobes)
  );

  lane_simd_datapath #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .SH_W   (SH_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .shiftAmt (shiftAmt),
    .resOut   (resOut),
    .resValid (resValid)
  );

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (resValid == $past(inValid)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(inValid)) |-> $stable(resOut));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (resOut == '0 && !resValid));

endmodule

// File: tb/lane_simd_alu_bench.sv
module lane_simd_alu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [3:0]  opSel = '0;
  logic [1:0]  satMode = '0;
  logic [3:0]  shiftAmt = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [63:0] resOut;
  logic        resValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_simd_alu u_lane_simd_alu (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel), .satMode(satMode),
    .shiftAmt(shiftAmt), .opA(opA), .opB(opB), .resOut(resOut), .resValid(resValid)
  );

  function automatic int clampS(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic logic [15:0] refLane(input int op, input int mode, input int amt,
                                          input logic [15:0] a, input logic [15:0] b);
    int ua = int'(a);
    int ub = int'(b);
    int sa = int'($signed(a));
    int sb = int'($signed(b));
    int r = 0;
    case (op)
      0: r = (mode == 1) ? clampS(sa + sb) :
             (mode == 2) ? ((ua + ub > 65535) ? 65535 : ua + ub) : ua + ub;
      1: r = (mode == 1) ? clampS(sa - sb) :
             (mode == 2) ? ((ua < ub) ? 0 : ua - ub) : ua - ub;
      2: r = ((ua + ub) / 2) | ((ua + ub) % 2);
      3: r = clampS(sa * (1 << (amt % 4)) + sb);
      4: r = clampS((sa >>> (amt % 4)) + sb);
      5: r = sa >>> amt;
      6: r = ua >> amt;
      7: r = ua << amt;
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  function automatic logic [63:0] refWord(input int op, input int mode, input int amt,
                                          input logic [63:0] a, input logic [63:0] b);
    logic [63:0] w;
    for (int i = 0; i < 4; i++) w[i*16 +: 16] = refLane(op, mode, amt, a[i*16 +: 16], b[i*16 +: 16]);
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic runOp(input string req, input int op, input int mode, input int amt,
                       input logic [63:0] a, input logic [63:0] b);
    opSel = op[3:0]; satMode = mode[1:0]; shiftAmt = amt[3:0];
    opA = a; opB = b; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    check(req, resOut, refWord(op, mode, amt, a, b));
    check({req, " valid"}, {63'd0, resValid}, 64'd1);
    inValid = 1'b0;
  endtask

  task automatic testReset;
    @(negedge clk);
    check("R9 reset out", resOut, 64'd0);
    check("R9 reset valid", {63'd0, resValid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic testWrap;
    runOp("R1 add wrap carry cut", 0, 0, 0, 64'hFFFF_0001_FFFF_7FFF, 64'h0001_0001_0001_0001);
    runOp("R1 sub wrap borrow cut", 1, 0, 0, 64'h0000_0005_0000_8000, 64'h0001_0001_0001_0001);
    runOp("R1 mode3 wraps", 0, 3, 0, 64'h7FFF_FFFF_8000_1234, 64'h0001_0002_8000_1111);
  endtask

  task automatic testSigned;
    runOp("R2 add ssat", 0, 1, 0, 64'h7FFF_8000_4000_FFFF, 64'h0001_FFFF_4000_0001);
    runOp("R2 sub ssat", 1, 1, 0, 64'h8000_7FFF_0005_FFFE, 64'h0001_FFFF_0007_7FFF);
  endtask

  task automatic testUnsigned;
    runOp("R3 add usat", 0, 2, 0, 64'hFFFF_8000_0001_7FFF, 64'h0001_8000_0002_0001);
    runOp("R3 sub usat", 1, 2, 0, 64'h0000_8000_0005_FFFF, 64'h0001_7FFF_0007_FFFF);
  endtask

  task automatic testAvg;
    runOp("R4 avg", 2, 0, 0, 64'hFFFF_0002_0000_FFFF, 64'hFFFF_0003_0001_0000);
  endtask

  task automatic testShiftAdd;
    runOp("R5 shladd k1", 3, 0, 1, 64'h4000_C000_0010_FFFF, 64'h0000_FFFF_0001_0001);
    runOp("R5 shladd k3", 3, 0, 3, 64'h1000_F000_0100_8000, 64'h0001_0000_FFFF_0000);
    runOp("R6 shradd k2", 4, 0, 2, 64'hFFFC_8000_0010_7FFF, 64'h0001_8000_7FFF_7FFF);
    runOp("R6 shradd k0", 4, 0, 0, 64'h7FFF_8000_1234_0001, 64'h0001_FFFF_0001_0001);
  endtask

  task automatic testShift;
    runOp("R7 shr signed 3", 5, 0, 3, 64'h8000_FFF0_7FFF_0008, 64'd0);
    runOp("R7 shr signed 15", 5, 0, 15, 64'h8000_7FFF_FFFF_0001, 64'd0);
    runOp("R7 shr logical 1", 6, 0, 1, 64'h8000_FFFF_0003_0001, 64'd0);
    runOp("R7 shl 15", 7, 0, 15, 64'h0001_0003_FFFF_0000, 64'd0);
    runOp("R7 shl 0", 7, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'd0);
  endtask

  task automatic testUndefined;
    runOp("R10 undefined op", 9, 1, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1111_2222_3333_4444);
  endtask

  task automatic testHoldReset;
    logic [63:0] kept;
    runOp("R8 load", 0, 0, 0, 64'h0102_0304_0506_0708, 64'h0101_0101_0101_0101);
    kept = refWord(0, 0, 0, 64'h0102_0304_0506_0708, 64'h0101_0101_0101_0101);
    opA = 64'hDEAD_BEEF_DEAD_BEEF; opSel = 4'd1;
    @(posedge clk); @(negedge clk);
    check("R8 hold out", resOut, kept);
    check("R8 valid low", {63'd0, resValid}, 64'd0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 mid reset", resOut, 64'd0);
    rst = 1'b0;
  endtask

  task automatic testRandom;
    for (int n = 0; n < 60; n++) begin
      int op = n % 8;
      runOp("R1 random", op, n % 4, $urandom_range(0, 15),
            {$urandom, $urandom}, {$urandom, $urandom});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    testReset();
    testWrap();
    testSigned();
    testUnsigned();
    testAvg();
    testShiftAdd();
    testShift();
    testUndefined();
    testHoldReset();
    testRandom();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule